// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

This block is a small, fully associative cache of page translations. It turns a virtual page number into a physical frame number for 8 KB pages. A 32-bit virtual address splits into a 19-bit page number (address bits 31:13) and a 13-bit byte offset. The offset bypasses translation and never enters the block. A lookup that matches a stored entry is answered combinationally in the cycle it is presented.

When a lookup matches no entry, the block reads the page table from memory by itself. The table is a single flat array indexed by virtual page number, with one 32-bit entry per page, starting at a base address supplied on an input. If the fetched entry says the page is resident, the translation is installed in the buffer and the pending lookup is answered as a hit. If the page is not resident, the block reports a fault and installs nothing. While a walk is in progress the lookup port is closed. A flush input empties the buffer in one cycle. When an entry must be replaced, the least recently used one is chosen.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `lookup_ready` is 1, `resp_valid` and `mem_req` are 0, and every entry is invalid, so the first lookup of any page misses.
- R2: A lookup accepted while `lookup_ready` is 1 that matches a valid entry drives `resp_valid`=1, `resp_hit`=1 and the stored frame on `resp_ppn` in the same cycle, and starts no memory read.
- R3: A lookup accepted while `lookup_ready` is 1 that matches no entry drives `resp_valid`=0 in that cycle. In the next cycle `mem_req` is 1 for exactly one cycle with `mem_addr` = `pt_base` + 4 × page number, and `lookup_ready` is 0.
- R4: A page-table word with bit 31 set is resident, and its bits 18:0 hold the frame. In the cycle after `mem_rvalid` returns such a word, the block drives `resp_valid`=1, `resp_hit`=1 and that frame, and later lookups of the page hit.
- R5: A returned word with bit 31 clear gives, in the next cycle, `resp_valid`=1, `resp_fault`=1, `resp_hit`=0 and `resp_ppn`=0. No entry is written, so a later lookup of the same page misses again.
- R6: A fill writes the lowest-numbered invalid entry. If every entry is valid, it writes the least recently used entry, where both hits and fills count as uses.
- R7: While `lookup_ready` is 0, `lookup_valid` is ignored. It starts no memory read, produces no response and installs nothing.
- R8: A one-cycle `flush` invalidates every entry. When `flush` falls in the same cycle as a fill, the flush wins and the new translation is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| pt_base | input | 32 | Byte address of page-table entry 0 |
| lookup_valid | input | 1 | Lookup request |
| lookup_vpn | input | 19 | Virtual page number to translate |
| lookup_ready | output | 1 | Lookup port open (no walk in progress) |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Response carries a translation |
| resp_fault | output | 1 | Page not resident |
| resp_ppn | output | 19 | Physical frame number |
| mem_req | output | 1 | One-cycle page-table read request |
| mem_addr | output | 32 | Byte address of the page-table word |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Page-table word (bit 31 resident, 18:0 frame) |

## Verification
Two pairs of functions can fall in the same cycle. A fill and a flush coincide when the bench raises `flush` in the very cycle the walk answers with its translation. Flush must take priority, so a fresh lookup of that page afterwards has to miss and start a new walk. A lookup offered during a walk coincides with the walk's own progress. The bench keeps `lookup_valid` high with a different page throughout a walk. It then checks that only one memory read was issued and that the second page is still absent. Replacement order is judged by filling all sixteen entries, touching chosen entries, and predicting which page each new fill evicts from the sequence of uses alone.

// File: rtl/xlat_pkg.sv
// Package: shared types for the page translation buffer.
// Assumes: page-table words are 32 bits wide with the resident flag in the top bit.
package xlat_pkg;

    // Miss-handling sequence of the table walker
    typedef enum logic [2:0] {
        WK_IDLE    = 3'd0,
        WK_REQUEST = 3'd1,
        WK_WAIT    = 3'd2,
        WK_FILL    = 3'd3,
        WK_FAULT   = 3'd4
    } walk_state_e;

    localparam int PTE_W        = 32;
    localparam int RESIDENT_BIT = PTE_W - 1;

endpackage

// File: rtl/xlat_cam.sv
// Module: xlat_cam
// Associative translation store. Compares a page number against every
// valid entry in parallel and returns the matching frame. Accepts one
// write per cycle and a global invalidate.
// Assumes: at most one entry matches any page number (the walker only
// fills on a miss); flush takes priority over a write of the valid bit.
module xlat_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 19,
    parameter int PPN_W   = 19,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [VPN_W-1:0]   tag_q   [ENTRIES];
    logic [PPN_W-1:0]   frame_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;

    // Per-entry comparators
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    end

    // Valid bits: cleared by reset or flush, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and frame storage written on a fill
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tag_q[i]   <= wr_vpn;
                frame_q[i] <= wr_ppn;
            end
        end
    end

    // Encode the single matching entry and select its frame
    always_comb begin
        lk_idx = '0;
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_idx = IDX_W'(i);
                lk_ppn = frame_q[i];
            end
        end
    end

    assign lk_hit    = |match;
    assign valid_vec = valid_q;

endmodule

// File: rtl/xlat_lru.sv
// Module: xlat_lru
// Exact least-recently-used tracker. Every entry carries an age equal to
// its rank in recency order (0 = newest). A use sets the entry's age to
// 0 and ages every entry that was newer than it. The victim is the
// lowest invalid entry, or else the entry whose age is ENTRIES-1.
// Assumes: ages form a permutation of 0..ENTRIES-1, which reset sets up
// and each update keeps.
module xlat_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    // Rank update on every use
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                age_q[i] <= IDX_W'(i);
            end else if (touch) begin
                if (touch_idx == IDX_W'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // Victim choice: free entry first, oldest entry otherwise
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !found) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == IDX_W'(ENTRIES - 1)) begin
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/xlat_walker.sv
// Module: xlat_walker
// Single-level page-table walker. On a miss it captures the page number,
// issues one read at base + 4 * page, waits for the data, and then spends
// one cycle in either a fill state (resident) or a fault state.
// Assumes: memory answers every request with exactly one mem_rvalid
// pulse, no earlier than the cycle after the request.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int VPN_W  = 19,
    parameter int PPN_W  = 19,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VPN_W-1:0]  start_vpn,
    input  logic [ADDR_W-1:0] pt_base,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              idle,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_en,
    output logic              fault,
    output logic [VPN_W-1:0]  held_vpn,
    output logic [PPN_W-1:0]  held_ppn
);

    walk_state_e      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;

    // Next-state selection for the walk sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:    if (start) state_d = WK_REQUEST;
            WK_REQUEST: state_d = WK_WAIT;
            WK_WAIT:    if (mem_rvalid) state_d = mem_rdata[RESIDENT_BIT] ? WK_FILL : WK_FAULT;
            WK_FILL:    state_d = WK_IDLE;
            WK_FAULT:   state_d = WK_IDLE;
            default:    state_d = WK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    // Capture the missing page number when a walk begins
    always_ff @(posedge clk) begin
        if (!rst_n)                          vpn_q <= '0;
        else if (state_q == WK_IDLE && start) vpn_q <= start_vpn;
    end

    // Capture the frame field of the returned table word
    always_ff @(posedge clk) begin
        if (!rst_n)                               ppn_q <= '0;
        else if (state_q == WK_WAIT && mem_rvalid) ppn_q <= mem_rdata[PPN_W-1:0];
    end

    assign idle     = (state_q == WK_IDLE);
    assign mem_req  = (state_q == WK_REQUEST);
    assign mem_addr = pt_base + ADDR_W'({vpn_q, 2'b00});
    assign fill_en  = (state_q == WK_FILL);
    assign fault    = (state_q == WK_FAULT);
    assign held_vpn = vpn_q;
    assign held_ppn = ppn_q;

endmodule

// File: rtl/xlat_cache.sv
// Module: xlat_cache (top)
// Fully associative page translation buffer. Hits are answered
// combinationally; misses hand over to the walker, which fills the victim
// chosen by the LRU tracker and answers the held lookup in its fill cycle.
// Assumes: the requester samples responses in the cycle resp_valid is
// high, and offers no lookup that needs an answer while lookup_ready is 0.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 19,
    parameter int PPN_W   = 19,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] pt_base,
    input  logic              lookup_valid,
    input  logic [VPN_W-1:0]  lookup_vpn,
    output logic              lookup_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic [PPN_W-1:0]  resp_ppn,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic               cam_hit;
    logic [IDX_W-1:0]   cam_idx;
    logic [PPN_W-1:0]   cam_ppn;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               walk_idle, fill_en, fault;
    logic [VPN_W-1:0]   held_vpn;
    logic [PPN_W-1:0]   held_ppn;
    logic               accept, fast_hit, start_walk, use_en;
    logic [IDX_W-1:0]   use_idx;

    // Lookup acceptance and hit/miss split
    assign accept     = lookup_valid && walk_idle;
    assign fast_hit   = accept && cam_hit;
    assign start_walk = accept && !cam_hit;

    // Recency update: a hit uses its entry, a fill uses the victim
    assign use_en  = fast_hit || fill_en;
    assign use_idx = fill_en ? victim_idx : cam_idx;

    xlat_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) cam_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (fill_en),
        .wr_idx    (victim_idx),
        .wr_vpn    (held_vpn),
        .wr_ppn    (held_ppn),
        .lk_vpn    (lookup_vpn),
        .lk_hit    (cam_hit),
        .lk_idx    (cam_idx),
        .lk_ppn    (cam_ppn),
        .valid_vec (valid_vec)
    );

    xlat_lru #(
        .ENTRIES (ENTRIES)
    ) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (use_en),
        .touch_idx  (use_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    xlat_walker #(
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W),
        .ADDR_W (ADDR_W)
    ) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_walk),
        .start_vpn  (lookup_vpn),
        .pt_base    (pt_base),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .idle       (walk_idle),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fill_en    (fill_en),
        .fault      (fault),
        .held_vpn   (held_vpn),
        .held_ppn   (held_ppn)
    );

    // Response merge: same-cycle hit, walk fill, or walk fault
    always_comb begin
        resp_valid = fast_hit || fill_en || fault;
        resp_hit   = fast_hit || fill_en;
        resp_fault = fault;
        if (fill_en)       resp_ppn = held_ppn;
        else if (fast_hit) resp_ppn = cam_ppn;
        else               resp_ppn = '0;
    end

    assign lookup_ready = walk_idle;

endmodule

// File: rtl/xlat_cache_chk.sv
// Module: xlat_cache_chk
// Port-level protocol checker for xlat_cache, attached by bind.
// Assumes: synchronous active-low reset shared with the design.
module xlat_cache_chk #(
    parameter int VPN_W  = 19,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [ADDR_W-1:0] pt_base,
    input logic              lookup_valid,
    input logic [VPN_W-1:0]  lookup_vpn,
    input logic              lookup_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_fault,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid
);

    logic             flush_q;
    logic [VPN_W-1:0] miss_vpn_q;

    // Remember that the previous cycle flushed
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= flush;
    end

    // Remember the page of the latest accepted miss
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_vpn_q <= '0;
        else if (lookup_valid && lookup_ready && !resp_valid)
            miss_vpn_q <= lookup_vpn;
    end

    // R2
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3
    req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == pt_base + ADDR_W'({miss_vpn_q, 2'b00})));

    // R4
    walk_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !lookup_ready) |-> $past(mem_rvalid));

    // R5
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && !resp_hit));

    // R7
    busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !lookup_ready);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && lookup_valid && lookup_ready) |-> !resp_hit);

endmodule

bind xlat_cache xlat_cache_chk #(
    .VPN_W  (VPN_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .pt_base      (pt_base),
    .lookup_valid (lookup_valid),
    .lookup_vpn   (lookup_vpn),
    .lookup_ready (lookup_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_fault   (resp_fault),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid)
);

// File: tb/xlat_cache_tb_top.sv
// Bench for xlat_cache: page-table contents are a formula of the page
// number, a memory model answers walks with variable latency, and every
// expectation comes from that formula and the stated replacement order.
module xlat_cache_tb_top;

    localparam int VPN_W  = 19;
    localparam int PPN_W  = 19;
    localparam int ADDR_W = 32;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic [ADDR_W-1:0] pt_base = BASE;
    logic              lookup_valid = 1'b0;
    logic [VPN_W-1:0]  lookup_vpn = '0;
    logic              lookup_ready, resp_valid, resp_hit, resp_fault;
    logic [PPN_W-1:0]  resp_ppn;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int req_count = 0;
    int mem_lat = 0;

    xlat_cache dut_i (
        .clk (clk), .rst_n (rst_n), .flush (flush), .pt_base (pt_base),
        .lookup_valid (lookup_valid), .lookup_vpn (lookup_vpn),
        .lookup_ready (lookup_ready), .resp_valid (resp_valid),
        .resp_hit (resp_hit), .resp_fault (resp_fault), .resp_ppn (resp_ppn),
        .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata)
    );

    always #5 clk = ~clk;

    function automatic bit f_res(input logic [VPN_W-1:0] v);
        return (int'(v) % 7) != 3;
    endfunction

    function automatic logic [PPN_W-1:0] f_ppn(input logic [VPN_W-1:0] v);
        return PPN_W'(int'(v) * 13 + 341);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: one response per request, mem_lat extra cycles
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [31:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    logic [VPN_W-1:0] v;
                    v = VPN_W'((a - BASE) >> 2);
                    mem_rvalid = 1'b1;
                    mem_rdata  = {f_res(v), 12'b0, f_ppn(v)};
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            if (mem_req) begin
                pend = 1;
                cnt  = mem_lat;
                a    = mem_addr;
            end
        end
    end

    // Count memory reads
    initial forever begin
        @(negedge clk);
        #2;
        if (mem_req) req_count++;
    end

    // One lookup; follows a walk to its end when it misses
    task automatic lookup(input logic [VPN_W-1:0] vpn, input bit exp_hit, input string tag,
                          input bit flush_fill, input bit hold_busy, input logic [VPN_W-1:0] busy_vpn);
        int w;
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_vpn   = vpn;
        #1;
        chk(resp_hit == exp_hit, tag, 32'(resp_hit), 32'(exp_hit));
        if (resp_hit) begin
            chk(resp_valid && resp_ppn == f_ppn(vpn), "R2 frame", 32'(resp_ppn), 32'(f_ppn(vpn)));
            @(negedge clk);
            lookup_valid = 1'b0;
            return;
        end
        chk(!resp_valid, "R3 no resp on miss", 32'(resp_valid), 0);
        @(negedge clk);
        lookup_valid = hold_busy;
        lookup_vpn   = busy_vpn;
        #1;
        chk(mem_req && !lookup_ready, "R3 request", {lookup_ready, 30'b0, mem_req}, 32'h1);
        chk(mem_addr == BASE + 32'(vpn) * 4, "R3 address", mem_addr, BASE + 32'(vpn) * 4);
        w = 0;
        while (!resp_valid && w < 20) begin
            @(negedge clk);
            #1;
            w++;
        end
        if (f_res(vpn)) begin
            chk(resp_valid && resp_hit && !resp_fault, "R4 fill resp", {resp_valid, resp_hit, resp_fault}, 3'b110);
            chk(resp_ppn == f_ppn(vpn), "R4 fill frame", 32'(resp_ppn), 32'(f_ppn(vpn)));
        end else begin
            chk(resp_valid && !resp_hit && resp_fault, "R5 fault resp", {resp_valid, resp_hit, resp_fault}, 3'b101);
            chk(resp_ppn == '0, "R5 fault frame", 32'(resp_ppn), 0);
        end
        if (flush_fill) flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [VPN_W-1:0] last_res = '0;
        int rc0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(lookup_ready && !resp_valid && !mem_req, "R1 reset state",
            {lookup_ready, resp_valid, mem_req}, 3'b100);

        // Sweep: first access misses, second hits or faults again
        for (int v = 0; v < 40; v++) begin
            logic [VPN_W-1:0] p;
            p = VPN_W'(v * 977 + 5);
            mem_lat = v % 4;
            lookup(p, 1'b0, "R1 first access misses", 1'b0, 1'b0, '0);
            if (f_res(p)) begin
                lookup(p, 1'b1, "R4 refilled page hits", 1'b0, 1'b0, '0);
                last_res = p;
            end else begin
                lookup(p, 1'b0, "R5 faulted page not installed", 1'b0, 1'b0, '0);
            end
        end

        // R8 flush empties the buffer
        lookup(last_res, 1'b1, "R2 hit before flush", 1'b0, 1'b0, '0);
        do_flush();
        lookup(last_res, 1'b0, "R8 miss after flush", 1'b0, 1'b0, '0);

        // R6 replacement order
        mem_lat = 1;
        do_flush();
        for (int k = 0; k < 16; k++)
            lookup(VPN_W'(256 + 7 * k), 1'b0, "R6 fill free entries", 1'b0, 1'b0, '0);
        for (int k = 0; k < 16; k++)
            lookup(VPN_W'(256 + 7 * k), 1'b1, "R6 all sixteen resident", 1'b0, 1'b0, '0);
        // Ages now follow order 0..15; refresh 0, then fill evicts 1
        lookup(VPN_W'(256), 1'b1, "R6 touch oldest", 1'b0, 1'b0, '0);
        lookup(VPN_W'(512), 1'b0, "R6 new page misses", 1'b0, 1'b0, '0);
        lookup(VPN_W'(256), 1'b1, "R6 touched page kept", 1'b0, 1'b0, '0);
        lookup(VPN_W'(256 + 14), 1'b1, "R6 page 2 kept", 1'b0, 1'b0, '0);
        lookup(VPN_W'(256 + 7), 1'b0, "R6 page 1 evicted", 1'b0, 1'b0, '0);
        lookup(VPN_W'(256 + 21), 1'b0, "R6 page 3 evicted next", 1'b0, 1'b0, '0);
        lookup(VPN_W'(256 + 35), 1'b1, "R6 page 5 still present", 1'b0, 1'b0, '0);
        lookup(VPN_W'(512), 1'b1, "R6 new page present", 1'b0, 1'b0, '0);

        // R7 lookups during a walk are ignored
        do_flush();
        mem_lat = 3;
        rc0 = req_count;
        lookup(VPN_W'(1024), 1'b0, "R7 walk start", 1'b0, 1'b1, VPN_W'(1025));
        chk(req_count - rc0 == 1, "R7 single read", 32'(req_count - rc0), 1);
        lookup(VPN_W'(1025), 1'b0, "R7 busy lookup not installed", 1'b0, 1'b0, '0);

        // R8 flush in the fill cycle wins
        do_flush();
        mem_lat = 0;
        lookup(VPN_W'(768), 1'b0, "R8 walk before flush", 1'b1, 1'b0, '0);
        lookup(VPN_W'(768), 1'b0, "R8 fill dropped by flush", 1'b0, 1'b0, '0);
        lookup(VPN_W'(768), 1'b1, "R4 later fill kept", 1'b0, 1'b0, '0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule